// File: doc/BRIEF.md
# Output Byte Arbiter with Interrupt Levels

This block decides which of four data sources supplies the single byte that a host reads from a keyboard/mouse controller's data port, and it produces the two interrupt levels for the host: one for keyboard-side data and one for mouse-side data. The sources are a byte the controller itself answers on the keyboard side, a byte the controller answers on the auxiliary (mouse) side, the head of the keyboard device queue and the head of the mouse device queue. The device queues and the command decoder sit outside. The decoder supplies the current mode byte and queues controller answers. The queues show a pending level with their head byte and accept a one-cycle pop pulse.

When the output buffer is empty, the highest-priority unmasked pending source is latched one clock later, and the buffer is marked full. The source is not latched while a keyboard throttle interval runs. A host read while full returns the latched source's byte, pops it and empties the buffer, so that arbitration runs again. An optional throttle holds arbitration off for a fixed time after a keyboard byte is read. That time is set in microseconds and turned into clock cycles from the clock frequency.

Top module: `obufArbiter`

## Requirements
- R1: After reset obFull, auxFull, irqKbd, irqMouse, kbdPop and mousePop are 0 and readData is 0.
- R2: With the buffer empty, the source latched is the first pending one in this order: keyboard-side controller answer, aux-side controller answer, keyboard data, mouse data.
- R3: Keyboard data is ignored while modeByte bit 4 is 1, and mouse data is ignored while modeByte bit 5 is 1. Controller answers are never ignored.
- R4: obFull rises on the clock edge after an eligible source is pending with the buffer empty. auxFull is 1 exactly when the latched source is an aux-side answer or mouse data.
- R5: irqMouse is 1 only when obFull, auxFull and modeByte bit 1 are all 1.
- R6: irqKbd is 1 only when obFull is 1, auxFull is 0, modeByte bit 0 is 1 and modeByte bit 4 is 0.
- R7: A hostRead cycle with obFull set loads readData with the latched source's byte and clears obFull, auxFull and both interrupts at that edge. In the same cycle it asserts kbdPop or mousePop if the source is a device, or drops the controller answer if the source is the controller.
- R8: A hostRead cycle with obFull clear leaves readData unchanged and pops nothing.
- R9: While obFull is set and no read occurs, new pending data does not change the latched source, auxFull or readData.
- R10: With throttling enabled, after a keyboard byte is read, no arbitration takes place for THROTTLE_US microseconds of clock cycles (CLK_HZ*THROTTLE_US/10^6). Arbitration resumes on the cycle after that.
- R11: Queuing a controller answer replaces any unread earlier answer and its side. Only the newest answer is ever delivered.
- R12: A modeByte change acts on irqKbd and irqMouse in the same cycle. A source it unmasks is latched at the next edge if the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeByte | input | 8 | Current controller mode: bit0 kbd IRQ enable, bit1 mouse IRQ enable, bit4 kbd off, bit5 mouse off |
| replyValid | input | 1 | Queue a controller answer this cycle |
| replyAux | input | 1 | Queued answer belongs to the aux side |
| replyByte | input | DATA_W | Controller answer byte |
| kbdPending | input | 1 | Keyboard queue holds a byte |
| kbdByte | input | DATA_W | Keyboard queue head byte |
| kbdPop | output | 1 | Consume the keyboard queue head |
| mousePending | input | 1 | Mouse queue holds a byte |
| mouseByte | input | DATA_W | Mouse queue head byte |
| mousePop | output | 1 | Consume the mouse queue head |
| hostRead | input | 1 | Host read strobe of the data port |
| readData | output | DATA_W | Byte returned to the host |
| obFull | output | 1 | Output buffer full |
| auxFull | output | 1 | Buffered byte is aux-side |
| irqKbd | output | 1 | Keyboard interrupt level |
| irqMouse | output | 1 | Mouse interrupt level |

## Verification
On every cycle the assertions check the interrupt gating against the mode bits and full flags, the link between auxFull and obFull, the clearing effect of a read, the stability of the buffer while it is full, and the pop pulses. Only the bench scenarios can show which source wins among several that are pending at once. The same holds for the masking by the disable bits, the length of the throttle interval, the replacement of an unread controller answer and the actual byte values returned to the host.

// File: rtl/obArbPkg.sv
package obArbPkg;

  localparam int MODE_W        = 8;
  localparam int MODE_KBD_IRQ  = 0;
  localparam int MODE_AUX_IRQ  = 1;
  localparam int MODE_KBD_OFF  = 4;
  localparam int MODE_AUX_OFF  = 5;

  typedef enum logic [1:0] {
    SRC_REPLY = 2'd0,
    SRC_KBD   = 2'd1,
    SRC_MOUSE = 2'd2
  } srcE;

  // strobes from control to datapath
  typedef struct packed {
    logic latchByte;
    srcE  latchSrc;
    logic clearReply;
  } dpStrobeT;

endpackage

// File: rtl/obArbCtrl.sv
module obArbCtrl
  import obArbPkg::*;
#(
  parameter bit THROTTLE_EN = 1'b0,
  parameter int THR_CYC     = 1,
  parameter int CNT_W       = 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     kbdOff,
  input  logic     auxOff,
  input  logic     kbdIrqEn,
  input  logic     auxIrqEn,
  input  logic     hostRead,
  input  logic     kbdPending,
  input  logic     mousePending,
  input  logic     replyKbdPending,
  input  logic     replyAuxPending,
  output logic     obFull,
  output logic     auxFull,
  output logic     irqKbd,
  output logic     irqMouse,
  output logic     kbdPop,
  output logic     mousePop,
  output dpStrobeT strobes
);

  logic obFullQ, auxFullQ;
  srcE  srcQ;
  logic kbdEff, mouseEff, anyReady, winAux;
  srcE  winSrc;
  logic throttleBusy, arbGo, readHit;

  // device flags gated by the mode disable bits; answers never gated
  assign kbdEff   = kbdPending & ~kbdOff;
  assign mouseEff = mousePending & ~auxOff;
  assign anyReady = replyKbdPending | replyAuxPending | kbdEff | mouseEff;

  // fixed priority selection
  always_comb begin
    winSrc = SRC_MOUSE;
    winAux = 1'b1;
    if (replyKbdPending) begin
      winSrc = SRC_REPLY;
      winAux = 1'b0;
    end else if (replyAuxPending) begin
      winSrc = SRC_REPLY;
      winAux = 1'b1;
    end else if (kbdEff) begin
      winSrc = SRC_KBD;
      winAux = 1'b0;
    end
  end

  assign readHit = hostRead & obFullQ;
  assign arbGo   = ~obFullQ & ~throttleBusy & anyReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      obFullQ  <= 1'b0;
      auxFullQ <= 1'b0;
      srcQ     <= SRC_REPLY;
    end else if (readHit) begin
      obFullQ  <= 1'b0;
      auxFullQ <= 1'b0;
    end else if (arbGo) begin
      obFullQ  <= 1'b1;
      auxFullQ <= winAux;
      srcQ     <= winSrc;
    end
  end

  generate
    if (THROTTLE_EN) begin : genThrottle
      logic [CNT_W-1:0] thrCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          thrCnt <= '0;
        end else if (readHit && srcQ == SRC_KBD) begin
          thrCnt <= CNT_W'(THR_CYC);
        end else if (thrCnt != '0) begin
          thrCnt <= thrCnt - 1'b1;
        end
      end
      assign throttleBusy = (thrCnt != '0);
    end else begin : genNoThrottle
      assign throttleBusy = 1'b0;
    end
  endgenerate

  assign obFull   = obFullQ;
  assign auxFull  = auxFullQ;
  assign irqMouse = obFullQ & auxFullQ & auxIrqEn;
  assign irqKbd   = obFullQ & ~auxFullQ & kbdIrqEn & ~kbdOff;
  assign kbdPop   = readHit & (srcQ == SRC_KBD);
  assign mousePop = readHit & (srcQ == SRC_MOUSE);

  assign strobes.latchByte  = readHit;
  assign strobes.latchSrc   = srcQ;
  assign strobes.clearReply = readHit & (srcQ == SRC_REPLY);

endmodule

// File: rtl/obArbData.sv
module obArbData
  import obArbPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobes,
  input  logic              replyValid,
  input  logic              replyAux,
  input  logic [DATA_W-1:0] replyByte,
  input  logic [DATA_W-1:0] kbdByte,
  input  logic [DATA_W-1:0] mouseByte,
  output logic [DATA_W-1:0] readData,
  output logic              replyKbdPending,
  output logic              replyAuxPending
);

  logic [DATA_W-1:0] replyReg;
  logic [DATA_W-1:0] pickByte;

  // a new answer replaces the old one and its side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      replyReg        <= '0;
      replyKbdPending <= 1'b0;
      replyAuxPending <= 1'b0;
    end else if (replyValid) begin
      replyReg        <= replyByte;
      replyKbdPending <= ~replyAux;
      replyAuxPending <= replyAux;
    end else if (strobes.clearReply) begin
      replyKbdPending <= 1'b0;
      replyAuxPending <= 1'b0;
    end
  end

  always_comb begin
    case (strobes.latchSrc)
      SRC_KBD:   pickByte = kbdByte;
      SRC_MOUSE: pickByte = mouseByte;
      default:   pickByte = replyReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readData <= '0;
    end else if (strobes.latchByte) begin
      readData <= pickByte;
    end
  end

endmodule

// File: rtl/obufArbiter.sv
module obufArbiter
  import obArbPkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter bit          THROTTLE_EN = 1'b1,
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned THROTTLE_US = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeByte,
  input  logic              replyValid,
  input  logic              replyAux,
  input  logic [DATA_W-1:0] replyByte,
  input  logic              kbdPending,
  input  logic [DATA_W-1:0] kbdByte,
  output logic              kbdPop,
  input  logic              mousePending,
  input  logic [DATA_W-1:0] mouseByte,
  output logic              mousePop,
  input  logic              hostRead,
  output logic [DATA_W-1:0] readData,
  output logic              obFull,
  output logic              auxFull,
  output logic              irqKbd,
  output logic              irqMouse
);

  localparam longint unsigned THR_PROD =
    (64'(CLK_HZ) * 64'(THROTTLE_US)) / 64'd1_000_000;
  localparam int THR_CYC = (THR_PROD > 64'd1) ? int'(THR_PROD) : 1;
  localparam int CNT_W   = $clog2(THR_CYC + 1);

  dpStrobeT strobes;
  logic     replyKbdPending, replyAuxPending;
  logic     modeUnused;

  assign modeUnused = ^{modeByte[7:6], modeByte[3:2]};

  obArbCtrl #(
    .THROTTLE_EN(THROTTLE_EN),
    .THR_CYC    (THR_CYC),
    .CNT_W      (CNT_W)
  ) uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .kbdOff         (modeByte[MODE_KBD_OFF]),
    .auxOff         (modeByte[MODE_AUX_OFF]),
    .kbdIrqEn       (modeByte[MODE_KBD_IRQ]),
    .auxIrqEn       (modeByte[MODE_AUX_IRQ]),
    .hostRead       (hostRead),
    .kbdPending     (kbdPending),
    .mousePending   (mousePending),
    .replyKbdPending(replyKbdPending),
    .replyAuxPending(replyAuxPending),
    .obFull         (obFull),
    .auxFull        (auxFull),
    .irqKbd         (irqKbd),
    .irqMouse       (irqMouse),
    .kbdPop         (kbdPop),
    .mousePop       (mousePop),
    .strobes        (strobes)
  );

  obArbData #(
    .DATA_W(DATA_W)
  ) uData (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .replyValid     (replyValid),
    .replyAux       (replyAux),
    .replyByte      (replyByte),
    .kbdByte        (kbdByte),
    .mouseByte      (mouseByte),
    .readData       (readData),
    .replyKbdPending(replyKbdPending),
    .replyAuxPending(replyAuxPending)
  );

endmodule

// File: rtl/obArbChecker.sv
module obArbChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        modeByte,
  input logic              hostRead,
  input logic [DATA_W-1:0] readData,
  input logic              obFull,
  input logic              auxFull,
  input logic              irqKbd,
  input logic              irqMouse,
  input logic              kbdPop,
  input logic              mousePop
);

  assert_irq_mouse_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqMouse |-> obFull && auxFull && modeByte[1]);

  assert_irq_kbd_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqKbd |-> obFull && !auxFull && modeByte[0] && !modeByte[4]);

  assert_aux_needs_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    auxFull |-> obFull);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    hostRead && obFull |=> !obFull && !auxFull && !irqKbd && !irqMouse);

  assert_pop_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({kbdPop, mousePop}));

  assert_kbd_pop_src_R7: assert property (@(posedge clk) disable iff (!rstN)
    kbdPop |-> hostRead && obFull && !auxFull);

  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    hostRead && !obFull |=> $stable(readData));

  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    !obFull |-> !kbdPop && !mousePop);

  assert_hold_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    obFull && !hostRead |=> obFull && $stable(auxFull) && $stable(readData));

endmodule

bind obufArbiter obArbChecker #(.DATA_W(DATA_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .modeByte(modeByte),
  .hostRead(hostRead),
  .readData(readData),
  .obFull  (obFull),
  .auxFull (auxFull),
  .irqKbd  (irqKbd),
  .irqMouse(irqMouse),
  .kbdPop  (kbdPop),
  .mousePop(mousePop)
);

// File: tb/obufArbiter_test.sv
module obufArbiter_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] modeByte = 8'h03;
  logic       replyValid = 1'b0, replyAux = 1'b0;
  logic [7:0] replyByte = 8'h00;
  logic       kbdPending, mousePending, kbdPop, mousePop;
  logic [7:0] kbdByte, mouseByte;
  logic       hostRead = 1'b0;
  logic [7:0] readData;
  logic       obFull, auxFull, irqKbd, irqMouse;

  always #4 clk = ~clk;  // 125 MHz

  // 1 us throttle at 125 MHz -> 125 cycles
  localparam int THR = 125;

  obufArbiter #(
    .DATA_W(8), .THROTTLE_EN(1'b1), .CLK_HZ(125_000_000), .THROTTLE_US(1)
  ) uut (
    .clk(clk), .rstN(rstN), .modeByte(modeByte),
    .replyValid(replyValid), .replyAux(replyAux), .replyByte(replyByte),
    .kbdPending(kbdPending), .kbdByte(kbdByte), .kbdPop(kbdPop),
    .mousePending(mousePending), .mouseByte(mouseByte), .mousePop(mousePop),
    .hostRead(hostRead), .readData(readData), .obFull(obFull),
    .auxFull(auxFull), .irqKbd(irqKbd), .irqMouse(irqMouse)
  );

  // device queue models
  logic [7:0] kbdMem [16];
  logic [7:0] mouseMem [16];
  int kbdHead = 0, kbdTail = 0, mouseHead = 0, mouseTail = 0;
  assign kbdPending   = (kbdHead != kbdTail);
  assign mousePending = (mouseHead != mouseTail);
  assign kbdByte      = kbdMem[kbdHead[3:0]];
  assign mouseByte    = mouseMem[mouseHead[3:0]];

  always @(posedge clk) begin
    if (kbdPop)   kbdHead   <= kbdHead + 1;
    if (mousePop) mouseHead <= mouseHead + 1;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      kbdMem[i] = 8'h00;
      mouseMem[i] = 8'h00;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic checkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       readSeen = 1'b0;

  always @(posedge clk) readSeen <= hostRead;

  always @(negedge clk) begin
    if (readSeen && expQ.size() != 0) begin
      checkEq(tagQ.pop_front(), int'(readData), int'(expQ.pop_front()));
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pushKbd(logic [7:0] b);
    kbdMem[kbdTail[3:0]] = b;
    kbdTail++;
  endtask

  task automatic pushMouse(logic [7:0] b);
    mouseMem[mouseTail[3:0]] = b;
    mouseTail++;
  endtask

  task automatic queueReply(logic aux, logic [7:0] b);
    replyValid = 1'b1;
    replyAux   = aux;
    replyByte  = b;
    tick();
    replyValid = 1'b0;
  endtask

  task automatic readExpect(logic [7:0] exp, string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    hostRead = 1'b1;
    tick();
    hostRead = 1'b0;
  endtask

  task automatic settle();
    repeat (THR + 5) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checkEq("R1 obFull", obFull, 0);
    checkEq("R1 auxFull", auxFull, 0);
    checkEq("R1 irqs", {irqKbd, irqMouse}, 0);
    checkEq("R1 readData", readData, 0);
    checkEq("R1 pops", {kbdPop, mousePop}, 0);
    rstN = 1'b1;
    tick();

    // keyboard byte: full, kbd irq
    pushKbd(8'hA1);
    tick();
    checkEq("R4 obFull kbd", obFull, 1);
    checkEq("R4 auxFull kbd", auxFull, 0);
    checkEq("R6 irqKbd", irqKbd, 1);
    checkEq("R5 irqMouse off", irqMouse, 0);
    // R9: mouse arrives while full, nothing changes
    pushMouse(8'hB2);
    tick(); tick();
    checkEq("R9 auxFull held", auxFull, 0);
    checkEq("R9 obFull held", obFull, 1);
    readExpect(8'hA1, "R7 kbd byte");
    checkEq("R7 kbd popped", kbdTail - kbdHead, 0);
    checkEq("R10 throttled", obFull, 0);
    settle();

    // mouse byte now arbitrated
    checkEq("R4 auxFull mouse", auxFull, 1);
    checkEq("R5 irqMouse", irqMouse, 1);
    checkEq("R6 irqKbd off", irqKbd, 0);
    modeByte = 8'h01;
    #1 checkEq("R12 irqMouse gated", irqMouse, 0);
    @(negedge clk);
    modeByte = 8'h03;
    #1 checkEq("R12 irqMouse back", irqMouse, 1);
    @(negedge clk);
    readExpect(8'hB2, "R7 mouse byte");
    checkEq("R7 irqs cleared", {irqKbd, irqMouse}, 0);

    // R3 masking + R8 empty read
    modeByte = 8'h23;
    pushMouse(8'hC3);
    tick(); tick();
    checkEq("R3 mouse masked", obFull, 0);
    readExpect(8'hB2, "R8 empty read repeats");
    checkEq("R8 no pop", mouseTail - mouseHead, 1);
    modeByte = 8'h03;
    tick();
    checkEq("R12 unmask arbitrates", obFull, 1);
    readExpect(8'hC3, "R3 mouse after unmask");

    // R2 priority
    pushMouse(8'h31);
    tick();
    pushKbd(8'h32);
    pushMouse(8'h33);
    queueReply(1'b1, 8'h34);
    tick();
    readExpect(8'h31, "R9 first latched kept");
    tick();
    checkEq("R2 aux answer aux flag", auxFull, 1);
    readExpect(8'h34, "R2 aux answer before kbd");
    tick();
    checkEq("R2 kbd before mouse", auxFull, 0);
    readExpect(8'h32, "R2 kbd data");
    settle();
    checkEq("R2 mouse last", auxFull, 1);
    readExpect(8'h33, "R2 mouse data");

    // kbd answer beats kbd data
    pushMouse(8'h41);
    tick();
    pushKbd(8'h42);
    queueReply(1'b0, 8'h43);
    readExpect(8'h41, "R2 mouse latched");
    tick();
    readExpect(8'h43, "R2 kbd answer first");
    tick();
    checkEq("R10 no throttle after answer", obFull, 1);
    readExpect(8'h42, "R2 kbd data after answer");
    settle();

    // R11 overwrite
    pushMouse(8'h51);
    tick();
    queueReply(1'b0, 8'h52);
    queueReply(1'b1, 8'h53);
    readExpect(8'h51, "R11 mouse first");
    tick();
    checkEq("R11 side replaced", auxFull, 1);
    readExpect(8'h53, "R11 newest answer");
    tick();
    checkEq("R11 old answer gone", obFull, 0);

    // R3 answers never masked, R6 gate by kbd off
    modeByte = 8'h33;
    queueReply(1'b0, 8'h61);
    tick();
    checkEq("R3 answer unmasked", obFull, 1);
    checkEq("R6 irqKbd off when disabled", irqKbd, 0);
    readExpect(8'h61, "R3 answer byte");
    modeByte = 8'h03;

    // R10 throttle length
    pushKbd(8'h71);
    pushKbd(8'h72);
    tick();
    readExpect(8'h71, "R10 first kbd");
    repeat (THR) @(posedge clk);
    @(negedge clk);
    checkEq("R10 still blocked", obFull, 0);
    tick();
    checkEq("R10 resumes", obFull, 1);
    readExpect(8'h72, "R10 second kbd");
    settle();

    // R12 kbd irq enable
    modeByte = 8'h02;
    pushKbd(8'h81);
    tick();
    checkEq("R6 irqKbd needs bit0", irqKbd, 0);
    modeByte = 8'h03;
    #1 checkEq("R12 irqKbd same cycle", irqKbd, 1);
    @(negedge clk);
    readExpect(8'h81, "R7 final kbd");
    tick();

    checkEq("scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule